// File: doc/BRIEF.md
# Bus System-Error Pulse and Parity Status Tracker

This block sits beside the parity checker of one agent on a shared parallel bus. Each clock it looks at the parity-check results: an address-phase error pulse and a data-phase error pulse. It also sees the agent's role (master or target), the transfer direction, whether a broadcast special cycle is being monitored, the sampled active-low data-parity-error line, and three command enables. From these it builds three results. The first is a one-clock enable for an open-drain, active-low system-error driver. The other two are the sticky status flags "master data parity error" and "detected parity error".

The system-error line is wire-ORed among all agents. For this reason the block also watches its sampled level. Once the line is seen low, the block reports it as asserted, or at least undefined. It keeps that report until the line has been sampled high on two clock edges in a row. Software clears either status flag by writing a one to that flag's bit position in the 16-bit status word.

The pulse generator has two states. PULSE_IDLE moves to PULSE_DRIVE when a qualified trigger is present. PULSE_DRIVE always returns to PULSE_IDLE on the next clock. The line monitor has three states. LINE_CLEAR moves to LINE_ASSERTED on a low sample. LINE_ASSERTED moves to LINE_RECOVER on a high sample. LINE_RECOVER returns to LINE_ASSERTED on a low sample, and moves to LINE_CLEAR after the second consecutive high sample.

Top module: `bus_syserr_status`

## Requirements
- R1: `serr_oe` rises only in the cycle after a trigger seen while both `cmd_serr_en` and `cmd_perr_resp` were 1. With either enable at 0, no trigger produces a pulse.
- R2: An address parity error (`addr_perr`=1) is a trigger whatever the values of `is_master`, `is_write` and `special_cycle`.
- R3: A data parity error is a trigger only when `special_cycle`=1 and `cmd_spc_en`=1. A data parity error outside a special cycle never raises `serr_oe`.
- R4: `serr_oe` is high for exactly one clock. A trigger that arrives while it is high is dropped. A trigger held high produces pulses on alternate cycles.
- R5: `serr_seen` goes to 1 in the cycle after `serr_in_n` is sampled 0. It goes back to 0 only in the cycle after `serr_in_n` has been sampled 1 on two consecutive edges. A 0 sample in between restarts the count.
- R6: `mdpe_status` becomes 1 in the cycle after a clock edge that sees all of the following: `cmd_perr_resp`=1, `is_master`=1, and either (`is_write`=0 with `data_perr`=1) or (`is_write`=1 with `perr_in_n`=0).
- R7: `mdpe_status` is never set while `is_master`=0 or `cmd_perr_resp`=0.
- R8: `dpe_status` becomes 1 in the cycle after `addr_perr`=1. It also becomes 1 after `data_perr`=1 when the agent is target of a write (`is_master`=0, `is_write`=1) or master of a read (`is_master`=1, `is_write`=0). This happens whatever the value of `cmd_perr_resp`.
- R9: Both flags are sticky. A clock with `stat_wr_en`=1 clears `mdpe_status` if `stat_wr_data` bit 8 is 1, and clears `dpe_status` if bit 15 is 1. A zero in either of these bits leaves that flag unchanged. A set condition in the same cycle wins over the clear.
- R10: While `rst_n`=0, `serr_oe`, `mdpe_status`, `dpe_status` and `serr_seen` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_perr | input | 1 | Address parity error detected this cycle |
| data_perr | input | 1 | Data parity error detected this cycle |
| is_master | input | 1 | Agent is master of the current transfer |
| is_write | input | 1 | Current transfer is a write |
| special_cycle | input | 1 | Current transfer is a monitored special cycle |
| perr_in_n | input | 1 | Sampled data-parity-error line, active low |
| cmd_serr_en | input | 1 | Command enable: system-error driving |
| cmd_perr_resp | input | 1 | Command enable: parity error response |
| cmd_spc_en | input | 1 | Command enable: special-cycle monitoring |
| stat_wr_en | input | 1 | Status word write strobe |
| stat_wr_data | input | 16 | Status write data, write-one-to-clear |
| serr_in_n | input | 1 | Sampled system-error line, active low |
| serr_oe | output | 1 | Enable for the open-drain driver that pulls the system-error line low |
| mdpe_status | output | 1 | Sticky master data parity error flag |
| dpe_status | output | 1 | Sticky detected parity error flag |
| serr_seen | output | 1 | System-error line is taken as asserted or not yet settled |

## Verification
The assertions assume that every input holds a known 0 or 1 value on each rising edge. They also assume that the error pulses and `perr_in_n` are already qualified by the surrounding bus logic, so any value seen at an edge is taken as a genuine event. The bench keeps to this. It drives every input from its tasks half a period away from the sampling edge and never leaves one undriven. Its stimulus mixes directed sequences with weighted pseudo-random values. These cover held triggers, enables that toggle, role and direction combinations, and glitchy system-error levels in which a single high sample is followed by a low one.

// File: rtl/bus_serr_pkg.sv
package bus_serr_pkg;

    typedef enum logic {
        PULSE_IDLE,
        PULSE_DRIVE
    } pulse_state_e;

    typedef enum logic [1:0] {
        LINE_CLEAR,
        LINE_ASSERTED,
        LINE_RECOVER
    } line_state_e;

endpackage

// File: rtl/serr_pulse_fsm.sv
module serr_pulse_fsm
    import bus_serr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic drive
);

    pulse_state_e state_q;
    pulse_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PULSE_IDLE:  if (trigger) state_d = PULSE_DRIVE;
            PULSE_DRIVE: state_d = PULSE_IDLE;
            default:     state_d = PULSE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PULSE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        drive = (state_q == PULSE_DRIVE);
    end

endmodule

// File: rtl/serr_line_monitor.sv
module serr_line_monitor
    import bus_serr_pkg::*;
#(
    parameter int HIGH_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic seen
);

    localparam int CNT_W = $clog2(HIGH_SAMPLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HIGH_SAMPLES - 1);

    line_state_e     state_q;
    line_state_e     state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LINE_CLEAR: begin
                cnt_d = '0;
                if (!line_n) state_d = LINE_ASSERTED;
            end
            LINE_ASSERTED: begin
                if (line_n) begin
                    if (HIGH_SAMPLES <= 1) begin
                        state_d = LINE_CLEAR;
                        cnt_d   = '0;
                    end else begin
                        state_d = LINE_RECOVER;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            LINE_RECOVER: begin
                if (!line_n) begin
                    state_d = LINE_ASSERTED;
                    cnt_d   = '0;
                end else if (cnt_q >= LAST_CNT) begin
                    state_d = LINE_CLEAR;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = LINE_CLEAR;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINE_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        seen = (state_q != LINE_CLEAR);
    end

endmodule

// File: rtl/parity_status_regs.sv
module parity_status_regs #(
    parameter int STAT_W    = 16,
    parameter int MDPE_POS  = 8,
    parameter int DPE_POS   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        set_req,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [1:0]        flags
);

    localparam int NUM_FLAGS = 2;

    logic wr_data_unused;
    assign wr_data_unused = ^wr_data;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        localparam int BIT_POS = (g == 0) ? MDPE_POS : DPE_POS;
        logic flag_q;
        logic clr;

        assign clr = wr_en && wr_data[BIT_POS];

        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q <= 1'b0;
            else if (set_req[g]) flag_q <= 1'b1;
            else if (clr)        flag_q <= 1'b0;
        end

        assign flags[g] = flag_q;
    end

endmodule

// File: rtl/bus_syserr_status.sv
module bus_syserr_status #(
    parameter int STAT_W       = 16,
    parameter int MDPE_POS     = 8,
    parameter int DPE_POS      = 15,
    parameter int HIGH_SAMPLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_perr,
    input  logic              data_perr,
    input  logic              is_master,
    input  logic              is_write,
    input  logic              special_cycle,
    input  logic              perr_in_n,
    input  logic              cmd_serr_en,
    input  logic              cmd_perr_resp,
    input  logic              cmd_spc_en,
    input  logic              stat_wr_en,
    input  logic [STAT_W-1:0] stat_wr_data,
    input  logic              serr_in_n,
    output logic              serr_oe,
    output logic              mdpe_status,
    output logic              dpe_status,
    output logic              serr_seen
);

    logic       serr_trigger;
    logic       mdpe_set;
    logic       dpe_set;
    logic [1:0] flags;

    always_comb begin
        serr_trigger = cmd_serr_en && cmd_perr_resp &&
                       (addr_perr || (data_perr && special_cycle && cmd_spc_en));
        mdpe_set     = cmd_perr_resp && is_master &&
                       ((!is_write && data_perr) || (is_write && !perr_in_n));
        dpe_set      = addr_perr ||
                       (data_perr && ((is_master && !is_write) || (!is_master && is_write)));
    end

    serr_pulse_fsm u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (serr_trigger),
        .drive   (serr_oe)
    );

    serr_line_monitor #(
        .HIGH_SAMPLES (HIGH_SAMPLES)
    ) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_n (serr_in_n),
        .seen   (serr_seen)
    );

    parity_status_regs #(
        .STAT_W   (STAT_W),
        .MDPE_POS (MDPE_POS),
        .DPE_POS  (DPE_POS)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req ({dpe_set, mdpe_set}),
        .wr_en   (stat_wr_en),
        .wr_data (stat_wr_data),
        .flags   (flags)
    );

    assign mdpe_status = flags[0];
    assign dpe_status  = flags[1];

endmodule

// File: rtl/bus_syserr_checker.sv
module bus_syserr_checker #(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_perr,
    input  logic              data_perr,
    input  logic              is_master,
    input  logic              is_write,
    input  logic              special_cycle,
    input  logic              perr_in_n,
    input  logic              cmd_serr_en,
    input  logic              cmd_perr_resp,
    input  logic              cmd_spc_en,
    input  logic              stat_wr_en,
    input  logic [STAT_W-1:0] stat_wr_data,
    input  logic              serr_in_n,
    input  logic              serr_oe,
    input  logic              mdpe_status,
    input  logic              dpe_status,
    input  logic              serr_seen
);

    a_r1_needs_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(serr_oe) |-> $past(cmd_serr_en && cmd_perr_resp));

    a_r2_addr_err_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_perr && cmd_serr_en && cmd_perr_resp && !serr_oe) |=> serr_oe);

    a_r3_plain_data_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_perr && !(data_perr && special_cycle && cmd_spc_en)) |=> !$rose(serr_oe));

    a_r4_single_clock_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        serr_oe |=> !serr_oe);

    a_r5_low_seen: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_in_n |=> serr_seen);

    a_r5_two_highs_to_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(serr_seen) |-> ($past(serr_in_n) && $past(serr_in_n, 2)));

    a_r7_no_target_mdpe: assert property (@(posedge clk) disable iff (!rst_n)
        (!mdpe_status && (!is_master || !cmd_perr_resp)) |=> !mdpe_status);

    a_r8_addr_err_sets_dpe: assert property (@(posedge clk) disable iff (!rst_n)
        addr_perr |=> dpe_status);

    a_r9_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_en && !stat_wr_data[15] && dpe_status) |=> dpe_status);

endmodule

bind bus_syserr_status bus_syserr_checker #(.STAT_W(STAT_W)) u_checker (.*);

// File: tb/tb_bus_syserr_status.sv
module tb_bus_syserr_status;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;
    localparam int RANDOM_CYCLES = 3000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        addr_perr, data_perr, is_master, is_write, special_cycle, perr_in_n;
    logic        cmd_serr_en, cmd_perr_resp, cmd_spc_en, stat_wr_en, serr_in_n;
    logic [15:0] stat_wr_data;
    logic        serr_oe, mdpe_status, dpe_status, serr_seen;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit m_oe, m_mdpe, m_dpe, m_seen;
    int m_highs;

    bus_syserr_status dut (
        .clk(clk), .rst_n(rst_n), .addr_perr(addr_perr), .data_perr(data_perr),
        .is_master(is_master), .is_write(is_write), .special_cycle(special_cycle),
        .perr_in_n(perr_in_n), .cmd_serr_en(cmd_serr_en), .cmd_perr_resp(cmd_perr_resp),
        .cmd_spc_en(cmd_spc_en), .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .serr_in_n(serr_in_n), .serr_oe(serr_oe), .mdpe_status(mdpe_status),
        .dpe_status(dpe_status), .serr_seen(serr_seen)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clock();
        bit trig, mset, dset;
        trig = cmd_serr_en && cmd_perr_resp &&
               (addr_perr || (data_perr && special_cycle && cmd_spc_en));
        mset = cmd_perr_resp && is_master &&
               ((!is_write && data_perr) || (is_write && !perr_in_n));
        dset = addr_perr || (data_perr && (is_master != is_write));
        if (!rst_n) begin
            m_oe = 0; m_mdpe = 0; m_dpe = 0; m_seen = 0; m_highs = 0;
        end else begin
            m_oe = !m_oe && trig;
            if (mset) m_mdpe = 1;
            else if (stat_wr_en && stat_wr_data[8]) m_mdpe = 0;
            if (dset) m_dpe = 1;
            else if (stat_wr_en && stat_wr_data[15]) m_dpe = 0;
            if (!serr_in_n) begin
                m_seen = 1; m_highs = 0;
            end else if (m_seen) begin
                m_highs++;
                if (m_highs >= 2) begin
                    m_seen = 0; m_highs = 0;
                end
            end
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_clock();
        @(negedge clk);
        chk({tag, " R1/R4 serr_oe"}, serr_oe, m_oe);
        chk({tag, " R6/R7 mdpe_status"}, mdpe_status, m_mdpe);
        chk({tag, " R8 dpe_status"}, dpe_status, m_dpe);
        chk({tag, " R5 serr_seen"}, serr_seen, m_seen);
    endtask

    task automatic quiet();
        addr_perr = 0; data_perr = 0; is_master = 0; is_write = 0;
        special_cycle = 0; perr_in_n = 1; serr_in_n = 1;
        stat_wr_en = 0; stat_wr_data = '0;
        cmd_serr_en = 1; cmd_perr_resp = 1; cmd_spc_en = 1;
    endtask

    task automatic clear_all();
        quiet();
        stat_wr_en = 1; stat_wr_data = 16'h8100;
        step("R9 clear");
        stat_wr_en = 0; stat_wr_data = '0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL WATCHDOG act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        quiet();
        rst_n = 0;
        addr_perr = 1; serr_in_n = 0;
        repeat (3) step("R10 reset");
        chk("R10 serr_oe in reset", serr_oe, 1'b0);
        chk("R10 dpe_status in reset", dpe_status, 1'b0);
        quiet();
        rst_n = 1;
        step("R10 after reset");

        // R2: address error as a non-involved target
        addr_perr = 1; is_master = 0; is_write = 1;
        step("R2 addr target");
        chk("R2 pulse", serr_oe, 1'b1);
        addr_perr = 0;
        step("R4 release");
        chk("R4 one clock", serr_oe, 1'b0);
        addr_perr = 1; is_master = 1; is_write = 0; special_cycle = 1;
        step("R2 addr master");
        chk("R2 pulse as master", serr_oe, 1'b1);
        quiet(); step("R2 idle");

        // R1: each enable blocks the pulse
        cmd_serr_en = 0; addr_perr = 1;
        step("R1 serr_en off");
        chk("R1 no pulse serr_en=0", serr_oe, 1'b0);
        cmd_serr_en = 1; cmd_perr_resp = 0;
        step("R1 perr_resp off");
        chk("R1 no pulse perr_resp=0", serr_oe, 1'b0);
        chk("R8 dpe set without perr_resp", dpe_status, 1'b1);
        quiet(); step("R1 idle");

        // R3: special-cycle data error
        data_perr = 1; special_cycle = 1; cmd_spc_en = 0;
        step("R3 spc off");
        chk("R3 no pulse spc_en=0", serr_oe, 1'b0);
        cmd_spc_en = 1;
        step("R3 spc on");
        chk("R3 pulse spc_en=1", serr_oe, 1'b1);
        quiet(); step("R3 idle");
        data_perr = 1; is_master = 0; is_write = 1;
        step("R3 plain data err");
        chk("R3 no pulse outside special cycle", serr_oe, 1'b0);
        quiet(); step("R3 idle2");

        // R4: held trigger
        addr_perr = 1;
        for (int i = 0; i < 4; i++) step("R4 held");
        quiet(); step("R4 idle");

        // R6 / R7 / R8
        clear_all();
        is_master = 1; is_write = 0; data_perr = 1;
        step("R6 master read");
        chk("R6 mdpe master read", mdpe_status, 1'b1);
        chk("R8 dpe master read", dpe_status, 1'b1);
        clear_all();
        is_master = 1; is_write = 1; perr_in_n = 0;
        step("R6 master write perr");
        chk("R6 mdpe master write", mdpe_status, 1'b1);
        chk("R8 dpe not set by perr line", dpe_status, 1'b0);
        clear_all();
        is_master = 0; is_write = 1; data_perr = 1; perr_in_n = 0;
        step("R7 target write");
        chk("R7 target no mdpe", mdpe_status, 1'b0);
        chk("R8 dpe target write", dpe_status, 1'b1);
        clear_all();
        is_master = 1; is_write = 0; data_perr = 1; cmd_perr_resp = 0;
        step("R7 resp off");
        chk("R7 no mdpe with resp=0", mdpe_status, 1'b0);
        chk("R8 dpe with resp=0", dpe_status, 1'b1);
        quiet();
        is_master = 0; is_write = 0; data_perr = 1;
        step("R8 target read");
        quiet(); step("R8 idle");

        // R9: write-one-to-clear
        is_master = 1; is_write = 0; data_perr = 1;
        step("R9 set both");
        quiet();
        stat_wr_en = 1; stat_wr_data = 16'h7EFF;
        step("R9 zero bits");
        chk("R9 mdpe kept", mdpe_status, 1'b1);
        chk("R9 dpe kept", dpe_status, 1'b1);
        stat_wr_data = 16'h0100;
        step("R9 clear bit8");
        chk("R9 mdpe cleared", mdpe_status, 1'b0);
        chk("R9 dpe kept2", dpe_status, 1'b1);
        stat_wr_data = 16'h8000; addr_perr = 1;
        step("R9 set wins");
        chk("R9 set over clear", dpe_status, 1'b1);
        quiet();
        stat_wr_en = 1; stat_wr_data = 16'h8000;
        step("R9 clear bit15");
        chk("R9 dpe cleared", dpe_status, 1'b0);
        quiet();

        // R5: line monitor
        serr_in_n = 0; step("R5 low");
        chk("R5 seen after low", serr_seen, 1'b1);
        serr_in_n = 1; step("R5 high1");
        chk("R5 still seen after one high", serr_seen, 1'b1);
        serr_in_n = 0; step("R5 low again");
        serr_in_n = 1; step("R5 high1b");
        chk("R5 restart count", serr_seen, 1'b1);
        step("R5 high2");
        chk("R5 clear after two highs", serr_seen, 1'b0);
        step("R5 idle");

        // mixed pseudo-random traffic
        for (int i = 0; i < RANDOM_CYCLES; i++) begin
            addr_perr     = ($urandom_range(0, 7) == 0);
            data_perr     = ($urandom_range(0, 3) == 0);
            is_master     = $urandom_range(0, 1);
            is_write      = $urandom_range(0, 1);
            special_cycle = ($urandom_range(0, 3) == 0);
            perr_in_n     = ($urandom_range(0, 4) != 0);
            cmd_serr_en   = ($urandom_range(0, 5) != 0);
            cmd_perr_resp = ($urandom_range(0, 5) != 0);
            cmd_spc_en    = $urandom_range(0, 1);
            stat_wr_en    = ($urandom_range(0, 5) == 0);
            stat_wr_data  = 16'($urandom);
            serr_in_n     = ($urandom_range(0, 2) != 0);
            step("RND");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule